// File: doc/BRIEF.md
# Scaler Phase Increment Calculator

This block turns a pair of picture sizes into the stepping values that a polyphase resampler needs. From the source and destination width and height it derives four fixed-point step sizes: horizontal and vertical, for luma and for the chroma plane. Each step size has 13 fractional bits and is rounded to nearest. It also derives the two chroma start offsets, which move the first chroma sample back by a quarter or half of a chroma line or sample spacing. How far depends on where the source chroma is sited relative to luma.

A single strobe starts a run. The block latches its inputs, sets both start offsets at once, and then feeds the four divisions one after another through one shared restoring divider. The divider takes one cycle per quotient bit. A one-cycle completion pulse marks the end of the run. A zero divisor is caught before it reaches the divider: the matching step size saturates and an error flag is raised.

Top module: `phase_step_calc`

## Requirements
- R1: Every step size is floor(((S << 13) + floor(D / 2)) / D) for source extent S and destination extent D. Only the low 16 bits appear at the output. The luma horizontal step uses the widths and the luma vertical step uses the heights.
- R2: The source format code is 0 for 4:2:0, 1 for 4:2:2, and 2 or 3 for 4:4:4. A 4:2:0 source halves (floor) both the chroma source width and the chroma source height. A 4:2:2 source halves only the chroma source width. A 4:4:4 source leaves both unchanged.
- R3: A destination format code of 1 (4:2:2) halves (floor) the chroma destination width before the chroma horizontal step is formed. Other codes leave the chroma destination width and height equal to the luma ones.
- R4: The chroma vertical start is a 32-bit two's-complement value. For a 4:2:0 source it is -2048 when the siting code is 0 or 1, and -4096 when the siting code is 4 or 5. In every other case it is 0.
- R5: The chroma horizontal start is a 32-bit two's-complement value. For a 4:2:0 source it is -2048 when the siting code is 1, 3 or 5. In every other case it is 0.
- R6: A destination extent of zero, including a chroma extent that halves to zero, sets that step size to 0xFFFF and raises `dim_err`. `dim_err` stays high until the next accepted start clears it.
- R7: Counted from the clock edge that accepts `start`, a nonzero divisor takes 28 cycles and a zero divisor takes 1 cycle. The four operations run in the order luma horizontal, luma vertical, chroma horizontal, chroma vertical. `done` is high for exactly one cycle, starting with the edge that ends the last operation.
- R8: `busy` is high from the edge that accepts `start` until the edge that raises `done`. A `start` seen while `busy` is high is ignored, and that run's results come only from the inputs latched when it was accepted.
- R9: After reset all step sizes, both start offsets, `busy`, `done` and `dim_err` are 0.
- R10: While idle with `start` low, all six result outputs and `dim_err` hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| src_fmt | input | 2 | Source format: 0 = 4:2:0, 1 = 4:2:2, 2/3 = 4:4:4 |
| dst_fmt | input | 2 | Destination format: 1 = 4:2:2, others = full chroma |
| siting | input | 3 | Source chroma siting code 0..5 (6, 7 = no offset) |
| src_w | input | 12 | Source luma width |
| src_h | input | 12 | Source luma height |
| dst_w | input | 12 | Destination luma width |
| dst_h | input | 12 | Destination luma height |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| dim_err | output | 1 | A zero divisor was seen in the last run |
| luma_hinc | output | 16 | Luma horizontal step size |
| luma_vinc | output | 16 | Luma vertical step size |
| chroma_hinc | output | 16 | Chroma horizontal step size |
| chroma_vinc | output | 16 | Chroma vertical step size |
| chroma_hstart | output | 32 | Chroma horizontal start offset |
| chroma_vstart | output | 32 | Chroma vertical start offset |

## Verification
The bench sweeps all eight siting codes with a 4:2:0 source and repeats some of them with other source formats. A design that ignored the source format would shift 4:4:4 chroma, and one that mixed up the siting decode would put the quarter offset on the wrong axis. It drives odd extents, so halving that rounded up or skipped the half-divisor rounding term would be off by one in the step size. It also uses a maximum-size source against a one-pixel destination, where a quotient that lost bits would differ in the low 16 bits. Zero destinations and a 4:2:2 destination of width 1 exercise the saturation path; a design that divided anyway would produce the wrong value and the wrong latency. A start pulse issued partway through a run checks that a design re-latching its inputs would be caught by changed results.

// File: rtl/phase_step_pkg.sv
package phase_step_pkg;

   typedef enum logic [1:0] {
      FMT_420 = 2'd0,
      FMT_422 = 2'd1,
      FMT_444 = 2'd2
   } plane_fmt_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_e;

   localparam int unsigned N_OPS = 4;

endpackage

// File: rtl/step_divider.sv
module step_divider #(
   parameter int unsigned NUM_W = 26,
   parameter int unsigned DEN_W = 12,
   parameter int unsigned Q_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [Q_W-1:0]   quo,
   output logic             valid
);
   localparam int unsigned CW = $clog2(NUM_W + 1);

   if (NUM_W < 2) begin : g_bad_num
      $error("step_divider: NUM_W too small");
   end

   logic [DEN_W-1:0] rem_q;
   logic [NUM_W-1:0] shf_q;
   logic [DEN_W-1:0] den_q;
   logic [CW-1:0]    cnt_q;
   logic             act_q;

   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;
   logic             fits;

   always_comb begin
      trial = {rem_q, shf_q[NUM_W-1]};
      diff  = trial - {1'b0, den_q};
      fits  = (trial >= {1'b0, den_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         shf_q <= '0;
         den_q <= '0;
         cnt_q <= '0;
         act_q <= 1'b0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (go) begin
            rem_q <= '0;
            shf_q <= num;
            den_q <= den;
            cnt_q <= CW'(NUM_W);
            act_q <= 1'b1;
         end else if (act_q) begin
            rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            shf_q <= {shf_q[NUM_W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               act_q <= 1'b0;
               valid <= 1'b1;
            end
         end
      end
   end

   if (Q_W <= NUM_W) begin : g_trunc
      assign quo = shf_q[Q_W-1:0];
   end else begin : g_extend
      assign quo = {{(Q_W-NUM_W){1'b0}}, shf_q};
   end

endmodule

// File: rtl/chroma_origin.sv
module chroma_origin
   import phase_step_pkg::*;
#(
   parameter int unsigned OFS_W  = 32,
   parameter int unsigned FRAC_W = 13
) (
   input  logic [1:0]       fmt,
   input  logic [2:0]       siting,
   output logic [OFS_W-1:0] h_ofs,
   output logic [OFS_W-1:0] v_ofs
);
   localparam logic [OFS_W-1:0] QTR  = OFS_W'(1) << (FRAC_W - 2);
   localparam logic [OFS_W-1:0] HALF = QTR << 1;

   logic sub420;

   always_comb begin
      sub420 = (fmt == FMT_420);
      v_ofs  = '0;
      h_ofs  = '0;
      if (sub420) begin
         case (siting)
            3'd0, 3'd1: v_ofs = -QTR;
            3'd4, 3'd5: v_ofs = -HALF;
            default:    v_ofs = '0;
         endcase
         case (siting)
            3'd1, 3'd3, 3'd5: h_ofs = -QTR;
            default:          h_ofs = '0;
         endcase
      end
   end

endmodule

// File: rtl/phase_step_calc.sv
module phase_step_calc
   import phase_step_pkg::*;
#(
   parameter int unsigned DIM_W  = 12,
   parameter int unsigned FRAC_W = 13,
   parameter int unsigned INC_W  = 16,
   parameter int unsigned OFS_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       src_fmt,
   input  logic [1:0]       dst_fmt,
   input  logic [2:0]       siting,
   input  logic [DIM_W-1:0] src_w,
   input  logic [DIM_W-1:0] src_h,
   input  logic [DIM_W-1:0] dst_w,
   input  logic [DIM_W-1:0] dst_h,
   output logic             busy,
   output logic             done,
   output logic             dim_err,
   output logic [INC_W-1:0] luma_hinc,
   output logic [INC_W-1:0] luma_vinc,
   output logic [INC_W-1:0] chroma_hinc,
   output logic [INC_W-1:0] chroma_vinc,
   output logic [OFS_W-1:0] chroma_hstart,
   output logic [OFS_W-1:0] chroma_vstart
);
   localparam int unsigned NUM_W = DIM_W + FRAC_W + 1;
   localparam int unsigned KW    = $clog2(N_OPS);

   if (FRAC_W < 2) begin : g_bad_frac
      $error("phase_step_calc: FRAC_W must be at least 2");
   end
   if (OFS_W <= FRAC_W) begin : g_bad_ofs
      $error("phase_step_calc: OFS_W must exceed FRAC_W");
   end

   seq_state_e       state_q;
   logic [KW-1:0]    op_q;
   logic [1:0]       sfmt_q, dfmt_q;
   logic [DIM_W-1:0] sw_q, sh_q, dw_q, dh_q;
   logic [INC_W-1:0] res_q [N_OPS];

   logic [DIM_W-1:0] c_sw, c_sh, c_dw, c_dh;
   logic [DIM_W-1:0] src_sel, den_sel;
   logic [NUM_W-1:0] num_sel;
   logic             den_zero;
   logic             div_go;
   logic [INC_W-1:0] div_quo;
   logic             div_valid;
   logic [OFS_W-1:0] org_h, org_v;
   logic             last_op;

   // chroma plane extents
   always_comb begin
      c_sw = (sfmt_q == FMT_420 || sfmt_q == FMT_422) ? (sw_q >> 1) : sw_q;
      c_sh = (sfmt_q == FMT_420) ? (sh_q >> 1) : sh_q;
      c_dw = (dfmt_q == FMT_422) ? (dw_q >> 1) : dw_q;
      c_dh = dh_q;
   end

   // operand selection, one division per op index
   always_comb begin
      case (op_q)
         KW'(0):  begin src_sel = sw_q; den_sel = dw_q; end
         KW'(1):  begin src_sel = sh_q; den_sel = dh_q; end
         KW'(2):  begin src_sel = c_sw; den_sel = c_dw; end
         default: begin src_sel = c_sh; den_sel = c_dh; end
      endcase
      num_sel  = NUM_W'({src_sel, {FRAC_W{1'b0}}}) + NUM_W'(den_sel >> 1);
      den_zero = (den_sel == '0);
      div_go   = (state_q == ST_ISSUE) && !den_zero;
      last_op  = (op_q == KW'(N_OPS - 1));
   end

   chroma_origin #(
      .OFS_W  (OFS_W),
      .FRAC_W (FRAC_W)
   ) u_origin (
      .fmt    (src_fmt),
      .siting (siting),
      .h_ofs  (org_h),
      .v_ofs  (org_v)
   );

   step_divider #(
      .NUM_W (NUM_W),
      .DEN_W (DIM_W),
      .Q_W   (INC_W)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .num   (num_sel),
      .den   (den_sel),
      .quo   (div_quo),
      .valid (div_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         op_q          <= '0;
         sfmt_q        <= '0;
         dfmt_q        <= '0;
         sw_q          <= '0;
         sh_q          <= '0;
         dw_q          <= '0;
         dh_q          <= '0;
         done          <= 1'b0;
         dim_err       <= 1'b0;
         chroma_hstart <= '0;
         chroma_vstart <= '0;
         for (int i = 0; i < N_OPS; i++) res_q[i] <= '0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  sfmt_q        <= src_fmt;
                  dfmt_q        <= dst_fmt;
                  sw_q          <= src_w;
                  sh_q          <= src_h;
                  dw_q          <= dst_w;
                  dh_q          <= dst_h;
                  op_q          <= '0;
                  dim_err       <= 1'b0;
                  chroma_hstart <= org_h;
                  chroma_vstart <= org_v;
                  state_q       <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (den_zero) begin
                  res_q[op_q] <= '1;
                  dim_err     <= 1'b1;
                  if (last_op) begin
                     state_q <= ST_IDLE;
                     done    <= 1'b1;
                  end else begin
                     op_q <= op_q + 1'b1;
                  end
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            default: begin
               if (div_valid) begin
                  res_q[op_q] <= div_quo;
                  if (last_op) begin
                     state_q <= ST_IDLE;
                     done    <= 1'b1;
                  end else begin
                     op_q    <= op_q + 1'b1;
                     state_q <= ST_ISSUE;
                  end
               end
            end
         endcase
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign luma_hinc   = res_q[0];
   assign luma_vinc   = res_q[1];
   assign chroma_hinc = res_q[2];
   assign chroma_vinc = res_q[3];

endmodule

// File: rtl/phase_step_chk.sv
module phase_step_chk #(
   parameter int unsigned INC_W  = 16,
   parameter int unsigned OFS_W  = 32,
   parameter int unsigned FRAC_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             dim_err,
   input logic [INC_W-1:0] luma_hinc,
   input logic [INC_W-1:0] luma_vinc,
   input logic [INC_W-1:0] chroma_hinc,
   input logic [INC_W-1:0] chroma_vinc,
   input logic [OFS_W-1:0] chroma_hstart,
   input logic [OFS_W-1:0] chroma_vstart
);
   localparam logic [OFS_W-1:0] NEG_Q = -(OFS_W'(1) << (FRAC_W - 2));
   localparam logic [OFS_W-1:0] NEG_H = -(OFS_W'(1) << (FRAC_W - 1));

   // R7: completion pulse lasts one cycle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: done coincides with leaving the busy state
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8: an accepted start makes the block busy and clears the error
   a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !dim_err));

   // R8: a start while busy leaves the latched offsets alone
   a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> ($stable(chroma_hstart) && $stable(chroma_vstart)));

   // R10: results hold while idle without a start
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(luma_hinc) && $stable(luma_vinc) &&
                             $stable(chroma_hinc) && $stable(chroma_vinc) &&
                             $stable(dim_err)));

   // R4: vertical start takes only one of three values
   a_r4_vstart_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (chroma_vstart == '0 || chroma_vstart == NEG_Q || chroma_vstart == NEG_H));

   // R5: horizontal start takes only one of two values
   a_r5_hstart_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (chroma_hstart == '0 || chroma_hstart == NEG_Q));

endmodule

bind phase_step_calc phase_step_chk #(
   .INC_W  (INC_W),
   .OFS_W  (OFS_W),
   .FRAC_W (FRAC_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .busy          (busy),
   .done          (done),
   .dim_err       (dim_err),
   .luma_hinc     (luma_hinc),
   .luma_vinc     (luma_vinc),
   .chroma_hinc   (chroma_hinc),
   .chroma_vinc   (chroma_vinc),
   .chroma_hstart (chroma_hstart),
   .chroma_vstart (chroma_vstart)
);

// File: tb/test_phase_step_calc.sv
`timescale 1ns/1ps
module test_phase_step_calc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  src_fmt = '0, dst_fmt = '0;
   logic [2:0]  siting = '0;
   logic [11:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
   logic        busy, done, dim_err;
   logic [15:0] luma_hinc, luma_vinc, chroma_hinc, chroma_vinc;
   logic [31:0] chroma_hstart, chroma_vstart;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   phase_step_calc i_phase_step_calc (
      .clk(clk), .rst_n(rst_n), .start(start),
      .src_fmt(src_fmt), .dst_fmt(dst_fmt), .siting(siting),
      .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
      .busy(busy), .done(done), .dim_err(dim_err),
      .luma_hinc(luma_hinc), .luma_vinc(luma_vinc),
      .chroma_hinc(chroma_hinc), .chroma_vinc(chroma_vinc),
      .chroma_hstart(chroma_hstart), .chroma_vstart(chroma_vstart)
   );

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint ref_step(longint s, longint d);
      if (d == 0) return 65535;
      return (((s << 13) + (d >> 1)) / d) & 64'hFFFF;
   endfunction

   task automatic run(input int sw, input int sh, input int dw, input int dh,
                      input int sf, input int df, input int sit, input bit poke);
      longint c_sw, c_sh, c_dw, c_dh;
      longint e_lh, e_lv, e_ch, e_cv, e_hs, e_vs;
      int lat, bad;
      bit e_err;
      c_sw = (sf == 0 || sf == 1) ? sw / 2 : sw;
      c_sh = (sf == 0) ? sh / 2 : sh;
      c_dw = (df == 1) ? dw / 2 : dw;
      c_dh = dh;
      e_lh = ref_step(sw, dw);
      e_lv = ref_step(sh, dh);
      e_ch = ref_step(c_sw, c_dw);
      e_cv = ref_step(c_sh, c_dh);
      e_err = (dw == 0) || (dh == 0) || (c_dw == 0) || (c_dh == 0);
      lat = ((dw == 0) ? 1 : 28) + ((dh == 0) ? 1 : 28) +
            ((c_dw == 0) ? 1 : 28) + ((c_dh == 0) ? 1 : 28);
      e_vs = 0; e_hs = 0;
      if (sf == 0) begin
         if (sit == 0 || sit == 1) e_vs = 32'hFFFF_F800;
         if (sit == 4 || sit == 5) e_vs = 32'hFFFF_F000;
         if (sit == 1 || sit == 3 || sit == 5) e_hs = 32'hFFFF_F800;
      end
      @(negedge clk);
      src_w = 12'(sw); src_h = 12'(sh); dst_w = 12'(dw); dst_h = 12'(dh);
      src_fmt = 2'(sf); dst_fmt = 2'(df); siting = 3'(sit);
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      bad = 0;
      for (int m = 0; m <= lat + 1; m++) begin
         @(negedge clk);
         if (done !== (m == lat) || busy !== (m < lat)) bad++;
         if (poke && m == 3) begin
            src_w = 12'd7; dst_w = 12'd3; src_h = 12'd9; dst_h = 12'd2;
            src_fmt = 2'd0; siting = (sit == 5) ? 3'd2 : 3'd5;
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
      end
      check("R7 done/busy timing mismatches", bad, 0);
      check("R1 luma_hinc", luma_hinc, e_lh);
      check("R1 luma_vinc", luma_vinc, e_lv);
      check("R2/R3 chroma_hinc", chroma_hinc, e_ch);
      check("R2 chroma_vinc", chroma_vinc, e_cv);
      check("R4 chroma_vstart", chroma_vstart, e_vs);
      check("R5 chroma_hstart", chroma_hstart, e_hs);
      check("R6 dim_err", dim_err, e_err);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 busy", busy, 0);
      check("R9 done", done, 0);
      check("R9 dim_err", dim_err, 0);
      check("R9 luma_hinc", luma_hinc, 0);
      check("R9 chroma_vinc", chroma_vinc, 0);
      check("R9 chroma_vstart", chroma_vstart, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: 4:4:4 downscale, chroma equal to luma
      run(1920, 1080, 1280, 720, 2, 2, 0, 0);
      // R2: 4:2:0 upscale across all siting codes (R4, R5)
      for (int s = 0; s < 8; s++) run(1280, 721, 1919, 1079, 0, 2, s, 0);
      // R2, R5: 4:4:4 source ignores siting
      run(800, 600, 640, 480, 3, 0, 5, 0);
      // R2, R3: 4:2:2 source into 4:2:2 destination, odd sizes
      run(1001, 601, 333, 777, 1, 1, 1, 0);
      // R6: 4:2:2 destination of width 1 halves to zero
      run(640, 480, 1, 240, 2, 1, 0, 0);
      // R6: zero destination height, and clear on next good run
      run(640, 480, 320, 0, 0, 2, 4, 0);
      run(100, 100, 100, 100, 2, 2, 0, 0);
      // R1: maximum source into a single pixel
      run(4095, 4095, 1, 2, 2, 2, 0, 0);
      // R8: start during a run is ignored
      run(1500, 900, 700, 1100, 0, 2, 1, 1);
      // R10: inputs wiggle while idle without a start
      begin
         logic [15:0] h0;
         logic [31:0] v0;
         h0 = luma_hinc; v0 = chroma_vstart;
         src_w = 12'd5; dst_w = 12'd9; siting = 3'd4; src_fmt = 2'd0;
         repeat (40) @(negedge clk);
         check("R10 luma_hinc held", luma_hinc, h0);
         check("R10 chroma_vstart held", chroma_vstart, v0);
         check("R10 busy stays low", busy, 0);
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule